// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block takes over the processor's bus writes when an exception is accepted. It arbitrates between a fast interrupt request, a normal interrupt request and two non-maskable traps: an illegal opcode and a division by a zero divisor. It captures the register values at the moment it accepts an event. It then emits the saved frame one byte at a time, onto a stack that grows downward. When the last byte is accepted, it raises a one-cycle request for the vector fetch. In the same cycle it hands back a new condition-code byte with the mask bits set.

The fast interrupt saves a short frame by default: the program counter and the condition code. When the full-frame mode input is high, the fast interrupt saves everything, as the normal interrupt and both traps always do. Bit 7 of the saved condition-code byte tells the return logic which kind of frame sits on the stack. Both traps share one vector. A cause output records which trap was taken last.

The byte writes form a valid/ready stream. Once `wr_valid` rises, `wr_addr` and `wr_data` hold steady until `wr_ready` is seen high at a clock edge. The stream never withdraws a byte. The consumer may hold `wr_ready` low for any number of cycles, and each such cycle stalls the whole sequence. All other pins are plain level or pulse signals.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `vec_req` and `cc_wr` are low and `trap_div` is 0.
- R2: A full frame is 14 bytes, written in this order: PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, F, E, B, A, then CC. It is the value of these inputs in the cycle the event was accepted.
- R3: The stack address is decremented before every write. The first byte goes to `sp_in`-1 and each later byte to one address lower. During `vec_req`, `sp_out` equals `sp_in` minus the frame length.
- R4: With `firq_full_mode` low, a fast-interrupt entry writes 3 bytes: PC low, PC high, CC. With `firq_full_mode` high, it writes the 14-byte full frame.
- R5: The saved CC byte has bit 7 set in a full frame and cleared in a short frame. All its other bits equal `cc_in`.
- R6: A normal interrupt is ignored while `irq_mask` is 1, and a fast interrupt is ignored while `firq_mask` is 1. Traps are taken whatever the masks are.
- R7: When several events are pending, a trap is taken first, then the fast interrupt, then the normal interrupt. If both traps are pending together, the illegal-opcode trap is taken first.
- R8: A trap pulse that arrives while an entry is in progress is remembered. It is taken after that entry finishes.
- R9: `vec_sel` is 0 for either trap, 1 for the fast interrupt and 2 for the normal interrupt. `trap_div` becomes 1 on a divide-by-zero trap and 0 on an illegal-opcode trap, and holds until the next trap.
- R10: `vec_req` and `cc_wr` are high for exactly one cycle, the cycle after the last byte is accepted. `cc_wr_data` is the saved CC with bit 4 set, and with bit 6 also set for a fast interrupt or a trap.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` do not change.
- R12: `busy` is high from the cycle after acceptance through the `vec_req` cycle. No new event is accepted while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Normal interrupt request, level |
| firq_req | input | 1 | Fast interrupt request, level |
| irq_mask | input | 1 | Blocks the normal interrupt when 1 |
| firq_mask | input | 1 | Blocks the fast interrupt when 1 |
| firq_full_mode | input | 1 | Fast interrupt saves the full frame when 1 |
| illegal_op | input | 1 | Illegal opcode fetched, one-cycle pulse |
| div_zero | input | 1 | Divide by zero divisor, one-cycle pulse |
| sp_in | input | AW | Stack pointer before entry |
| pc_in | input | 16 | Program counter to save |
| u_in | input | 16 | User stack pointer to save |
| y_in | input | 16 | Index Y to save |
| x_in | input | 16 | Index X to save |
| dp_in | input | 8 | Direct page to save |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| e_in | input | 8 | Accumulator E |
| f_in | input | 8 | Accumulator F |
| cc_in | input | 8 | Condition code to save |
| wr_ready | input | 1 | Consumer accepts the current byte |
| busy | output | 1 | Entry sequence in progress |
| wr_valid | output | 1 | A stack byte is offered |
| wr_addr | output | AW | Address of the offered byte |
| wr_data | output | 8 | Offered byte |
| sp_out | output | AW | Stack pointer after entry, valid with vec_req |
| vec_req | output | 1 | One-cycle vector fetch request |
| vec_sel | output | 2 | Vector to fetch: 0 trap, 1 fast, 2 normal |
| cc_wr | output | 1 | Load cc_wr_data into the CC register |
| cc_wr_data | output | 8 | Condition code with masks set |
| trap_div | output | 1 | Cause of the last trap: 1 divide, 0 illegal |

## Verification
The interesting collisions are a trap flag that arrives in the same cycle as pending interrupts, and the two trap flags that rise together. The bench drives a divide-by-zero pulse together with both interrupt requests, and separately drives both trap pulses at once. A behavioural model in the bench works out which entry must win in each case, and the order of `vec_sel` values shows that nothing was lost. A trap pulse landing in the middle of a stall caused by back-pressure is also provoked. It is judged by the bench seeing a second, trap-vectored entry follow directly.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    SRC_TRAP = 2'd0,
    SRC_FIRQ = 2'd1,
    SRC_IRQ  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  localparam int FULL_LEN  = 14;
  localparam int SHORT_LEN = 3;
  localparam int NWORDS    = 4;
  localparam int CC_ENT    = 7;
  localparam int CC_FMASK  = 6;
  localparam int CC_IMASK  = 4;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic can_take,
  input  logic irq_req,
  input  logic firq_req,
  input  logic irq_mask,
  input  logic firq_mask,
  input  logic ill_pulse,
  input  logic dz_pulse,
  output logic take,
  output src_e src,
  output logic take_dz
);
  logic pend_ill, pend_dz;
  logic ill_now, dz_now;
  logic pick_dz;

  assign ill_now = pend_ill | ill_pulse;
  assign dz_now  = pend_dz | dz_pulse;

  always_comb begin
    src     = SRC_NONE;
    pick_dz = 1'b0;
    if (ill_now) begin
      src = SRC_TRAP;
    end else if (dz_now) begin
      src     = SRC_TRAP;
      pick_dz = 1'b1;
    end else if (firq_req && !firq_mask) begin
      src = SRC_FIRQ;
    end else if (irq_req && !irq_mask) begin
      src = SRC_IRQ;
    end
  end

  assign take    = can_take && (src != SRC_NONE);
  assign take_dz = take && pick_dz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_ill <= 1'b0;
      pend_dz  <= 1'b0;
    end else begin
      pend_ill <= ill_now && !(take && (src == SRC_TRAP) && !pick_dz);
      pend_dz  <= dz_now && !take_dz;
    end
  end

  // R8
  dz_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dz_pulse || pend_dz) && !take_dz |=> pend_dz);

  // R8
  ill_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_pulse || pend_ill) && !take |=> pend_ill);
endmodule

// File: rtl/exc_frame.sv
module exc_frame
  import exc_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            full,
  input  logic [15:0]     pc,
  input  logic [15:0]     u,
  input  logic [15:0]     y,
  input  logic [15:0]     x,
  input  logic [7:0]      dp,
  input  logic [7:0]      acc_a,
  input  logic [7:0]      acc_b,
  input  logic [7:0]      acc_e,
  input  logic [7:0]      acc_f,
  input  logic [7:0]      cc,
  input  logic [IDXW-1:0] idx,
  output logic [7:0]      byte_out,
  output logic [7:0]      cc_saved
);
  logic [NWORDS-1:0][15:0] words;
  logic [7:0] frame_d [FULL_LEN];
  logic [7:0] frame_q [FULL_LEN];
  logic [7:0] cc_full, cc_short;

  assign words    = {x, y, u, pc};
  assign cc_full  = cc | 8'(1 << CC_ENT);
  assign cc_short = cc & ~8'(1 << CC_ENT);

  always_comb begin
    for (int w = 0; w < NWORDS; w++) begin
      frame_d[2*w]   = words[w][7:0];
      frame_d[2*w+1] = words[w][15:8];
    end
    frame_d[2*NWORDS]   = dp;
    frame_d[2*NWORDS+1] = acc_f;
    frame_d[2*NWORDS+2] = acc_e;
    frame_d[2*NWORDS+3] = acc_b;
    frame_d[2*NWORDS+4] = acc_a;
    frame_d[FULL_LEN-1] = cc_full;
    if (!full) begin
      frame_d[SHORT_LEN-1] = cc_short;
      for (int k = SHORT_LEN; k < FULL_LEN; k++) frame_d[k] = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < FULL_LEN; k++) frame_q[k] <= 8'h00;
      cc_saved <= 8'h00;
    end else if (load) begin
      for (int k = 0; k < FULL_LEN; k++) frame_q[k] <= frame_d[k];
      cc_saved <= full ? cc_full : cc_short;
    end
  end

  assign byte_out = (int'(idx) < FULL_LEN) ? frame_q[idx] : 8'h00;

  // R5
  entire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cc_saved[CC_ENT] == $past(full)));
endmodule

// File: rtl/exc_stacker.sv
module exc_stacker #(
  parameter int AW   = 16,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   sp_start,
  input  logic [IDXW-1:0] len,
  input  logic            wr_ready,
  output logic            wr_valid,
  output logic [AW-1:0]   wr_addr,
  output logic [IDXW-1:0] idx,
  output logic            last_done
);
  logic            active;
  logic [AW-1:0]   addr_q;
  logic [IDXW-1:0] idx_q, left_q;
  logic            fire, is_last;

  assign fire      = active && wr_ready;
  assign is_last   = (left_q == IDXW'(1));
  assign last_done = fire && is_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      addr_q <= sp_start - AW'(1);
      idx_q  <= '0;
      left_q <= len;
    end else if (fire) begin
      idx_q  <= idx_q + IDXW'(1);
      left_q <= left_q - IDXW'(1);
      if (is_last) active <= 1'b0;
      else         addr_q <= addr_q - AW'(1);
    end
  end

  assign wr_valid = active;
  assign wr_addr  = addr_q;
  assign idx      = idx_q;

  // R11
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && !start |=> wr_valid && $stable(wr_addr) && $stable(idx));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !is_last && !start |=> wr_addr == $past(wr_addr) - AW'(1));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic          firq_req,
  input  logic          irq_mask,
  input  logic          firq_mask,
  input  logic          firq_full_mode,
  input  logic          illegal_op,
  input  logic          div_zero,
  input  logic [AW-1:0] sp_in,
  input  logic [15:0]   pc_in,
  input  logic [15:0]   u_in,
  input  logic [15:0]   y_in,
  input  logic [15:0]   x_in,
  input  logic [7:0]    dp_in,
  input  logic [7:0]    a_in,
  input  logic [7:0]    b_in,
  input  logic [7:0]    e_in,
  input  logic [7:0]    f_in,
  input  logic [7:0]    cc_in,
  input  logic          wr_ready,
  output logic          busy,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] sp_out,
  output logic          vec_req,
  output logic [1:0]    vec_sel,
  output logic          cc_wr,
  output logic [7:0]    cc_wr_data,
  output logic          trap_div
);
  localparam int IDXW = $clog2(FULL_LEN + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_VEC} st_e;

  st_e             state;
  src_e            src, src_q;
  logic            take, take_dz, full_sel, last_done;
  logic [IDXW-1:0] len, idx;
  logic [7:0]      cc_saved;
  logic            trap_div_q;

  exc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .can_take(state == ST_IDLE),
    .irq_req(irq_req), .firq_req(firq_req),
    .irq_mask(irq_mask), .firq_mask(firq_mask),
    .ill_pulse(illegal_op), .dz_pulse(div_zero),
    .take(take), .src(src), .take_dz(take_dz)
  );

  assign full_sel = (src != SRC_FIRQ) || firq_full_mode;
  assign len      = full_sel ? IDXW'(FULL_LEN) : IDXW'(SHORT_LEN);

  exc_frame #(.IDXW(IDXW)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(take), .full(full_sel),
    .pc(pc_in), .u(u_in), .y(y_in), .x(x_in), .dp(dp_in),
    .acc_a(a_in), .acc_b(b_in), .acc_e(e_in), .acc_f(f_in), .cc(cc_in),
    .idx(idx), .byte_out(wr_data), .cc_saved(cc_saved)
  );

  exc_stacker #(.AW(AW), .IDXW(IDXW)) u_stk (
    .clk(clk), .rst_n(rst_n), .start(take), .sp_start(sp_in), .len(len),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .idx(idx), .last_done(last_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      src_q      <= SRC_NONE;
      trap_div_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          state <= ST_PUSH;
          src_q <= src;
          if (src == SRC_TRAP) trap_div_q <= take_dz;
        end
        ST_PUSH: if (last_done) state <= ST_VEC;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign vec_req    = (state == ST_VEC);
  assign cc_wr      = vec_req;
  assign vec_sel    = src_q;
  assign sp_out     = wr_addr;
  assign trap_div   = trap_div_q;
  assign cc_wr_data = cc_saved | 8'(1 << CC_IMASK)
                    | ((src_q != SRC_IRQ) ? 8'(1 << CC_FMASK) : 8'h00);

  // R10
  vec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> !vec_req);

  // R12
  vec_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> busy && !wr_valid);

  // R12
  stream_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_valid);

  // R7
  firq_over_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && firq_req && !firq_mask |=> vec_sel != 2'd2);
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req = 0, firq_req = 0, irq_mask = 0, firq_mask = 0, firq_full_mode = 0;
  logic illegal_op = 0, div_zero = 0, wr_ready = 1;
  logic [15:0] sp_in = 16'h8000, pc_in = 0, u_in = 0, y_in = 0, x_in = 0;
  logic [7:0] dp_in = 0, a_in = 0, b_in = 0, e_in = 0, f_in = 0, cc_in = 0;
  logic busy, wr_valid, vec_req, cc_wr, trap_div;
  logic [15:0] wr_addr, sp_out;
  logic [7:0] wr_data, cc_wr_data;
  logic [1:0] vec_sel;

  always #10 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .firq_req(firq_req),
    .irq_mask(irq_mask), .firq_mask(firq_mask), .firq_full_mode(firq_full_mode),
    .illegal_op(illegal_op), .div_zero(div_zero), .sp_in(sp_in), .pc_in(pc_in),
    .u_in(u_in), .y_in(y_in), .x_in(x_in), .dp_in(dp_in), .a_in(a_in),
    .b_in(b_in), .e_in(e_in), .f_in(f_in), .cc_in(cc_in), .wr_ready(wr_ready),
    .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .sp_out(sp_out), .vec_req(vec_req), .vec_sel(vec_sel), .cc_wr(cc_wr),
    .cc_wr_data(cc_wr_data), .trap_div(trap_div)
  );

  int checks = 0, fails = 0;
  string sc_tag = "";
  bit stall_mode = 0;
  bit done = 0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] act=%0h exp=%0h", tag, sc_tag, act, exp);
    end
  endfunction

  // behavioural reference model
  int ph = 0, m_src = 0, m_len = 0;
  bit pill = 0, pdz = 0, m_tdiv = 0, m_full = 0;
  logic [7:0] q[$];
  logic [15:0] m_addr = 0;
  logic [7:0] m_cc = 0;
  bit ill, dz;
  int s;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; pill = 0; pdz = 0; m_tdiv = 0; q.delete();
    end else begin
      ill = pill | illegal_op;
      dz  = pdz | div_zero;
      if (ph == 0) begin
        s = -1;
        if (ill) begin s = 0; m_tdiv = 0; ill = 0; end
        else if (dz) begin s = 0; m_tdiv = 1; dz = 0; end
        else if (firq_req && !firq_mask) s = 1;
        else if (irq_req && !irq_mask) s = 2;
        if (s >= 0) begin
          m_src  = s;
          m_full = (s != 1) || firq_full_mode;
          q.delete();
          q.push_back(pc_in[7:0]); q.push_back(pc_in[15:8]);
          if (m_full) begin
            q.push_back(u_in[7:0]); q.push_back(u_in[15:8]);
            q.push_back(y_in[7:0]); q.push_back(y_in[15:8]);
            q.push_back(x_in[7:0]); q.push_back(x_in[15:8]);
            q.push_back(dp_in); q.push_back(f_in); q.push_back(e_in);
            q.push_back(b_in); q.push_back(a_in);
            q.push_back(cc_in | 8'h80);
          end else begin
            q.push_back(cc_in & 8'h7F);
          end
          m_len  = q.size();
          m_cc   = q[q.size()-1] | 8'h10 | ((s != 2) ? 8'h40 : 8'h00);
          m_addr = sp_in - 16'd1;
          ph = 1;
        end
      end else if (ph == 1) begin
        if (wr_ready) begin
          void'(q.pop_front());
          if (q.size() == 0) ph = 2;
          else m_addr = m_addr - 16'd1;
        end
      end else begin
        ph = 0;
      end
      pill = ill;
      pdz  = dz;
    end
  end

  // per-cycle comparison, handshake count, ready driver
  int hs = 0;
  int seen[$];
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (ph != 0), "R12 busy", busy, ph != 0);
      chk(wr_valid == (ph == 1), "R2 valid", wr_valid, ph == 1);
      if (ph == 1) begin
        chk(wr_data == q[0], "R2 data", wr_data, q[0]);
        chk(wr_addr == m_addr, "R3 R11 address", wr_addr, m_addr);
        if (q.size() == 1)
          chk(wr_data[7] == m_full, "R5 entire flag", wr_data[7], m_full);
      end
      chk(vec_req == (ph == 2), "R10 vec_req", vec_req, ph == 2);
      chk(cc_wr == (ph == 2), "R10 cc_wr", cc_wr, ph == 2);
      if (ph == 2) begin
        chk(vec_sel == m_src, "R9 vector", vec_sel, m_src);
        chk(cc_wr_data == m_cc, "R10 mask byte", cc_wr_data, m_cc);
        chk(sp_out == m_addr, "R3 final sp", sp_out, m_addr);
        chk(hs == m_len, "R4 frame length", hs, m_len);
        seen.push_back(int'(vec_sel));
        hs = 0;
      end
      chk(trap_div == m_tdiv, "R9 cause", trap_div, m_tdiv);
      wr_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      if (wr_valid && wr_ready) hs++;
    end
  end

  task automatic new_regs();
    pc_in = 16'($urandom); u_in = 16'($urandom); y_in = 16'($urandom);
    x_in = 16'($urandom); dp_in = 8'($urandom); a_in = 8'($urandom);
    b_in = 8'($urandom); e_in = 8'($urandom); f_in = 8'($urandom);
    cc_in = 8'($urandom); sp_in = 16'($urandom);
  endtask

  task automatic wait_vec();
    do @(negedge clk); while (!vec_req);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sc_tag = "R1 reset";
    chk(busy == 0, "R1 busy", busy, 0);
    chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);
    chk(vec_req == 0 && cc_wr == 0, "R1 vec_req", vec_req, 0);
    chk(trap_div == 0, "R1 trap_div", trap_div, 0);

    // R2: normal interrupt, full frame
    sc_tag = "R2 irq";
    new_regs(); irq_req = 1; wait_vec(); irq_req = 0; settle(2);

    // R4 R5: fast interrupt, short then full
    sc_tag = "R4 firq short";
    new_regs(); firq_full_mode = 0; firq_req = 1; wait_vec(); firq_req = 0; settle(2);
    sc_tag = "R4 firq full";
    new_regs(); firq_full_mode = 1; firq_req = 1; wait_vec(); firq_req = 0; settle(2);
    firq_full_mode = 0;

    // R6: masked requests are ignored
    sc_tag = "R6 masked";
    seen.delete();
    irq_mask = 1; firq_mask = 1; irq_req = 1; firq_req = 1;
    settle(10);
    chk(busy == 0 && seen.size() == 0, "R6 masked ignored", seen.size(), 0);
    irq_req = 0; firq_req = 0;
    // R6: trap ignores masks
    new_regs(); illegal_op = 1; @(negedge clk); illegal_op = 0; wait_vec(); settle(2);
    chk(seen.size() == 1 && seen[0] == 0, "R6 trap unmasked", seen.size(), 1);
    irq_mask = 0; firq_mask = 0;

    // R9: divide trap cause
    sc_tag = "R9 div";
    new_regs(); div_zero = 1; @(negedge clk); div_zero = 0; wait_vec(); settle(2);
    chk(trap_div == 1, "R9 div cause", trap_div, 1);

    // R7: trap, fast and normal raised in one cycle
    sc_tag = "R7 collide";
    seen.delete();
    new_regs(); div_zero = 1; firq_req = 1; irq_req = 1;
    @(negedge clk); div_zero = 0;
    wait_vec(); new_regs();
    wait_vec(); firq_req = 0;
    wait_vec(); irq_req = 0; settle(2);
    chk(seen.size() == 3 && seen[0] == 0 && seen[1] == 1 && seen[2] == 2,
        "R7 order", seen.size() == 3 ? seen[1] * 16 + seen[2] : -1, 16'h12);

    // R7: both traps together, illegal first then divide
    sc_tag = "R7 two traps";
    seen.delete();
    new_regs(); illegal_op = 1; div_zero = 1; @(negedge clk);
    illegal_op = 0; div_zero = 0;
    wait_vec();
    chk(trap_div == 0, "R7 illegal first", trap_div, 0);
    wait_vec(); settle(2);
    chk(seen.size() == 2 && trap_div == 1, "R7 divide second", seen.size(), 2);

    // R8 R11: trap pulse during a stalled entry
    sc_tag = "R8 R11 stall";
    seen.delete();
    stall_mode = 1;
    new_regs(); irq_req = 1; @(negedge clk); irq_req = 0;
    settle(4); div_zero = 1; @(negedge clk); div_zero = 0;
    wait_vec(); wait_vec(); settle(2);
    chk(seen.size() == 2 && seen[0] == 2 && seen[1] == 0, "R8 trap remembered",
        seen.size(), 2);
    for (int n = 0; n < 6; n++) begin
      new_regs(); firq_full_mode = n[0]; firq_req = 1; @(negedge clk);
      firq_req = 0; wait_vec(); settle(1);
    end
    stall_mode = 0;
    settle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog [%s] act=%0d exp=%0d", sc_tag, 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule